// File: doc/BRIEF.md
# Stage Event Interrupt Controller

This block gathers the per-stage results of a twelve-stage measurement sequencer and turns them into one interrupt line. For every stage it keeps a sticky flag for "below the low limit", another for "above the high limit", and a third class of flags for "conversion finished". A thirteenth stage slot exists for the finished class only. Each class has its own enable mask. Only enabled events set flags, and only enabled flags drive the interrupt.

A host reads the flag words through a simple select-and-strobe port. Finished flags clear on every read. A limit flag clears on a read only when its stage's latest reported limit state is no longer exceeded. An event that lands in the same cycle as a clearing read keeps its flag set. In touch mode a limit flag is raised whenever a stage's exceeded state changes, so the host hears about both touch and release. The interrupt pin is registered once and then passed through a polarity select.

Events arrive as a valid strobe with a stage index and three qualifiers. The block takes one event in every cycle and never applies back-pressure, so no ready signal is provided. The sequencer must not present more than one stage per cycle.

Top module: `stage_irq_ctrl`

## Requirements
- R1: During and right after reset, all three flag words read zero and the pin is at its inactive level.
- R2: An event with `evt_valid`=1, index s in 0..11 and `evt_low`=1 (or `evt_high`=1) sets bit s of the low (or high) flag word only if bit s of `en_low` (or `en_high`) is 1. Outside touch mode this happens in the cycle after the event. A masked event, or an index of 12 or more, leaves both words unchanged.
- R3: An event with `evt_valid`=1, `evt_done`=1 and index s in 0..12 sets bit s of the finished word when `en_done[s]`=1. A masked event leaves the word unchanged.
- R4: A read of the low or high word clears a set bit only if the most recent event for that stage reported the limit as not exceeded. A bit whose stage is still exceeded stays set.
- R5: A read of the finished word clears all of its bits.
- R6: A read returns the word as it was before that cycle's clear. An event that sets a bit in the same cycle as a clearing read leaves the bit set.
- R7: With `touch_mode`=1, a limit bit is set when the stage's reported exceeded state differs from the previous report for that stage, in either direction. A report equal to the previous one sets nothing.
- R8: The pin reflects, one clock later, the OR of all flag bits whose enable bit is 1. It is active high when `irq_active_high`=1 and active low when it is 0. The polarity applies at once without a clock.
- R9: `rd_sel` picks the word: 0 = low flags in bits [11:0], 1 = high flags in bits [11:0], 2 = finished flags in bits [12:0], 3 = all zero. Unused upper bits read zero, and masked-out set bits are still visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | Event strobe, one stage per cycle |
| evt_stage | input | 4 | Stage index of the event |
| evt_low | input | 1 | Stage is below its low limit |
| evt_high | input | 1 | Stage is above its high limit |
| evt_done | input | 1 | Stage conversion finished |
| touch_mode | input | 1 | 1 = flag limit changes in both directions |
| en_low | input | 12 | Low-limit enable mask |
| en_high | input | 12 | High-limit enable mask |
| en_done | input | 13 | Finished enable mask |
| irq_active_high | input | 1 | Pin polarity, 1 = active high |
| rd_en | input | 1 | Read strobe, clears the selected word |
| rd_sel | input | 2 | Word select |
| rd_data | output | 16 | Selected word, valid in the strobe cycle |
| irq_pin | output | 1 | Interrupt output |

## Verification
The bench tests whether a read leaves a flag set while its stage is still exceeded. A design that cleared it anyway would lose an active touch. It also tests whether a release report sets a flag in touch mode. For that it sets up a stage whose exceeded state was captured while masked, so only a correct release edge can raise the flag. A design that compared against the flag instead of the stored state would stay silent. The bench also covers an event that coincides with a clearing read, which a wrong priority would drop. It checks that out-of-range indices and masked events change nothing, and that clearing an enable drops the pin while the flag stays visible.

// File: rtl/stage_irq_pkg.sv
package stage_irq_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_DONE = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/limit_tracker.sv
module limit_tracker #(
  parameter int STAGES = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [IDX_W-1:0]  evt_stage,
  input  logic              evt_over,
  input  logic              touch_mode,
  input  logic [STAGES-1:0] enable,
  input  logic              rd_clr,
  output logic [STAGES-1:0] status,
  output logic [STAGES-1:0] level
);
  localparam logic [IDX_W:0] STAGE_LIM = (IDX_W+1)'(STAGES);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic hit;
    logic nxt_lvl;
    logic set_bit;
    assign hit = evt_valid && (evt_stage == IDX_W'(s));

    always_comb begin
      nxt_lvl = hit ? evt_over : level[s];
      if (touch_mode) set_bit = hit && enable[s] && (evt_over != level[s]);
      else            set_bit = hit && enable[s] && evt_over;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        level[s]  <= 1'b0;
        status[s] <= 1'b0;
      end else begin
        level[s] <= nxt_lvl;
        if (set_bit)                 status[s] <= 1'b1;
        else if (rd_clr && !nxt_lvl) status[s] <= 1'b0;
      end
    end
  end

  AST_MASK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(enable)) == '0)); // R2

  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !evt_valid) |=> (status == ($past(status) & $past(level)))); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && ({1'b0, evt_stage} < STAGE_LIM) && enable[evt_stage] && evt_over && !touch_mode)
    |=> status[$past(evt_stage)]); // R6

  AST_TOUCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_mode && evt_valid && ({1'b0, evt_stage} < STAGE_LIM) && !rd_clr &&
     (evt_over == level[evt_stage])) |=> (status == $past(status))); // R7
endmodule

// File: rtl/done_tracker.sv
module done_tracker #(
  parameter int SLOTS = 13,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [IDX_W-1:0] evt_stage,
  input  logic             evt_done,
  input  logic [SLOTS-1:0] enable,
  input  logic             rd_clr,
  output logic [SLOTS-1:0] status
);
  localparam logic [IDX_W:0] SLOT_LIM = (IDX_W+1)'(SLOTS);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic set_bit;
    assign set_bit = evt_valid && evt_done && enable[s] && (evt_stage == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)       status[s] <= 1'b0;
      else if (set_bit) status[s] <= 1'b1;
      else if (rd_clr)  status[s] <= 1'b0;
    end
  end

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !evt_valid) |=> (status == '0)); // R5

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_done && ({1'b0, evt_stage} < SLOT_LIM) && enable[evt_stage])
    |=> status[$past(evt_stage)]); // R3
endmodule

// File: rtl/irq_driver.sv
module irq_driver #(
  parameter int STAGES = 12,
  parameter int SLOTS  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] low_st,
  input  logic [STAGES-1:0] high_st,
  input  logic [SLOTS-1:0]  done_st,
  input  logic [STAGES-1:0] en_low,
  input  logic [STAGES-1:0] en_high,
  input  logic [SLOTS-1:0]  en_done,
  input  logic              active_high,
  output logic              pin
);
  logic irq_raw;
  logic irq_q;

  assign irq_raw = (|(low_st & en_low)) | (|(high_st & en_high)) | (|(done_st & en_done));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_raw;
  end

  assign pin = active_high ? irq_q : ~irq_q;
endmodule

// File: rtl/stage_irq_ctrl.sv
module stage_irq_ctrl #(
  parameter int STAGES = 12,
  parameter int SLOTS  = 13,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  input  logic [$clog2(SLOTS)-1:0] evt_stage,
  input  logic                     evt_low,
  input  logic                     evt_high,
  input  logic                     evt_done,
  input  logic                     touch_mode,
  input  logic [STAGES-1:0]        en_low,
  input  logic [STAGES-1:0]        en_high,
  input  logic [SLOTS-1:0]         en_done,
  input  logic                     irq_active_high,
  input  logic                     rd_en,
  input  logic [1:0]               rd_sel,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     irq_pin
);
  import stage_irq_pkg::*;

  localparam int IDX_W = $clog2(SLOTS);

  rd_sel_e           sel;
  logic [STAGES-1:0] low_st, high_st, low_lvl, high_lvl;
  logic [SLOTS-1:0]  done_st;
  logic              clr_low, clr_high, clr_done;

  assign sel      = rd_sel_e'(rd_sel);
  assign clr_low  = rd_en && (sel == SEL_LOW);
  assign clr_high = rd_en && (sel == SEL_HIGH);
  assign clr_done = rd_en && (sel == SEL_DONE);

  limit_tracker #(.STAGES(STAGES), .IDX_W(IDX_W)) u_low (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_stage(evt_stage),
    .evt_over(evt_low), .touch_mode(touch_mode), .enable(en_low),
    .rd_clr(clr_low), .status(low_st), .level(low_lvl)
  );

  limit_tracker #(.STAGES(STAGES), .IDX_W(IDX_W)) u_high (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_stage(evt_stage),
    .evt_over(evt_high), .touch_mode(touch_mode), .enable(en_high),
    .rd_clr(clr_high), .status(high_st), .level(high_lvl)
  );

  done_tracker #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_done (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_stage(evt_stage),
    .evt_done(evt_done), .enable(en_done), .rd_clr(clr_done), .status(done_st)
  );

  irq_driver #(.STAGES(STAGES), .SLOTS(SLOTS)) u_irq (
    .clk(clk), .rst_n(rst_n), .low_st(low_st), .high_st(high_st), .done_st(done_st),
    .en_low(en_low), .en_high(en_high), .en_done(en_done),
    .active_high(irq_active_high), .pin(irq_pin)
  );

  always_comb begin
    case (sel)
      SEL_LOW:  rd_data = DATA_W'(low_st);
      SEL_HIGH: rd_data = DATA_W'(high_st);
      SEL_DONE: rd_data = DATA_W'(done_st);
      default:  rd_data = '0;
    endcase
  end

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(((low_st & en_low) == '0) && ((high_st & en_high) == '0) && ((done_st & en_done) == '0))
    |-> (irq_pin == !irq_active_high)); // R8

  AST_PIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(((low_st & en_low) != '0) && rst_n) |-> (irq_pin == irq_active_high)); // R8
endmodule

// File: tb/stage_irq_ctrl_test.sv
`timescale 1ns/1ps
module stage_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [3:0]  evt_stage = '0;
  logic        evt_low = 1'b0, evt_high = 1'b0, evt_done = 1'b0;
  logic        touch_mode = 1'b0;
  logic [11:0] en_low = '0, en_high = '0;
  logic [12:0] en_done = '0;
  logic        irq_active_high = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        irq_pin;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  stage_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_stage(evt_stage),
    .evt_low(evt_low), .evt_high(evt_high), .evt_done(evt_done),
    .touch_mode(touch_mode), .en_low(en_low), .en_high(en_high), .en_done(en_done),
    .irq_active_high(irq_active_high), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_pin(irq_pin)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected word for every read strobe
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rd_data, 16'hxxxx);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  // driver: one cycle of stimulus, optional read with its expected word
  task automatic cyc(input logic v, input int stg, input logic lo, input logic hi,
                     input logic dn, input logic rd, input logic [1:0] sel,
                     input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    evt_valid = v; evt_stage = 4'(stg); evt_low = lo; evt_high = hi; evt_done = dn;
    rd_en = rd; rd_sel = sel;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(posedge clk); #1;
    evt_valid = 1'b0; evt_low = 1'b0; evt_high = 1'b0; evt_done = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ev(input int stg, input logic lo, input logic hi, input logic dn);
    cyc(1'b1, stg, lo, hi, dn, 1'b0, 2'd0, 16'h0, "");
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, sel, exp, tag);
  endtask

  task automatic pin_chk(input logic exp, input string tag);
    @(posedge clk); #1;
    check(tag, {15'h0, irq_pin}, {15'h0, exp});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 pin inactive in reset", {15'h0, irq_pin}, 16'h1);
    rst_n = 1'b1;
    rd(2'd0, 16'h0, "R1 low word after reset");
    rd(2'd1, 16'h0, "R1 high word after reset");
    rd(2'd2, 16'h0, "R1 done word after reset");
    pin_chk(1'b1, "R1 pin idle after reset");

    // masked events and out-of-range index
    ev(3, 1'b1, 1'b1, 1'b0);
    rd(2'd0, 16'h0, "R2 masked low event");
    en_low = '1; en_high = '1;
    ev(13, 1'b1, 1'b1, 1'b0);
    rd(2'd0, 16'h0, "R2 index 13 ignored low");
    rd(2'd1, 16'h0, "R2 index 13 ignored high");
    en_low = '0; en_high = '0;
    ev(3, 1'b0, 1'b0, 1'b0);

    // low limit, active-low pin, clear rules
    en_low = 12'h008;
    ev(3, 1'b1, 1'b0, 1'b0);
    pin_chk(1'b0, "R8 active-low pin asserted");
    rd(2'd0, 16'h0008, "R2 low bit 3 set");
    rd(2'd0, 16'h0008, "R4 kept while exceeded");
    ev(3, 1'b0, 1'b0, 1'b0);
    rd(2'd0, 16'h0008, "R4 still set before clearing read");
    rd(2'd0, 16'h0000, "R4 cleared once not exceeded");
    pin_chk(1'b1, "R8 pin released by read");
    ev(3, 1'b0, 1'b0, 1'b0);
    rd(2'd0, 16'h0000, "R2 not-exceeded report sets nothing");

    irq_active_high = 1'b1;
    #1 check("R8 polarity idle level", {15'h0, irq_pin}, 16'h0);

    // high limit on stage 11
    en_high = 12'h800;
    ev(11, 1'b0, 1'b1, 1'b0);
    pin_chk(1'b1, "R8 active-high pin asserted");
    rd(2'd1, 16'h0800, "R2 high bit 11 set");
    ev(11, 1'b0, 1'b0, 1'b0);
    rd(2'd1, 16'h0800, "R4 high kept until read");
    rd(2'd1, 16'h0000, "R4 high cleared");
    pin_chk(1'b0, "R8 pin released after high read");

    // conversion finished flags
    en_done = 13'h1000;
    ev(12, 1'b0, 1'b0, 1'b1);
    pin_chk(1'b1, "R8 pin on finished stage 12");
    rd(2'd2, 16'h1000, "R3 finished bit 12 set");
    rd(2'd2, 16'h0000, "R5 finished cleared by read");
    ev(5, 1'b0, 1'b0, 1'b1);
    rd(2'd2, 16'h0000, "R3 masked finished ignored");
    rd(2'd3, 16'h0000, "R9 select 3 reads zero");

    // enable gating of the pin, flag still visible
    en_done = '0; en_high = '0;
    en_low = 12'h008;
    ev(3, 1'b1, 1'b0, 1'b0);
    en_low = '0;
    pin_chk(1'b0, "R8 disabled flag drives no pin");
    rd(2'd0, 16'h0008, "R9 masked flag visible");
    ev(3, 1'b0, 1'b0, 1'b0);
    rd(2'd0, 16'h0008, "R4 masked flag kept until read");
    rd(2'd0, 16'h0000, "R4 masked flag cleared");

    // event coinciding with a clearing read
    en_low = 12'h004;
    cyc(1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000, "R6 read shows pre-event word");
    rd(2'd0, 16'h0004, "R6 event beat the clear");
    ev(2, 1'b0, 1'b0, 1'b0);
    rd(2'd0, 16'h0004, "R6 cleanup read");
    rd(2'd0, 16'h0000, "R4 stage 2 cleared");

    // touch mode
    touch_mode = 1'b1;
    ev(2, 1'b1, 1'b0, 1'b0);
    rd(2'd0, 16'h0004, "R7 touch raises flag");
    ev(2, 1'b0, 1'b0, 1'b0);
    rd(2'd0, 16'h0004, "R7 release report");
    rd(2'd0, 16'h0000, "R7 cleared after release");
    ev(2, 1'b0, 1'b0, 1'b0);
    rd(2'd0, 16'h0000, "R7 repeated state sets nothing");
    en_high = '0;
    ev(7, 1'b0, 1'b1, 1'b0);
    rd(2'd1, 16'h0000, "R7 masked touch sets nothing");
    en_high = 12'h080;
    ev(7, 1'b0, 1'b0, 1'b0);
    pin_chk(1'b1, "R7 release drives pin");
    rd(2'd1, 16'h0080, "R7 release alone raises flag");
    rd(2'd1, 16'h0000, "R7 release flag cleared");
    ev(2, 1'b1, 1'b0, 1'b0);
    rd(2'd0, 16'h0004, "R7 second touch");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check("R9 reads left unchecked", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule